// File: doc/BRIEF.md
# Load-Use Interlock and Operand Forwarding Control

This block is the hazard controller of a four-stage in-order pipeline (fetch, operand read, ALU, write-back/memory). Each cycle it looks at the register fields and instruction class held in the instruction registers of stages 1, 2 and 3. From these it decides where each of stage 1's two ALU holding registers takes its value. The choices are the register file, the ALU output of the stage 2 instruction, the write-back value of the stage 3 instruction (memory data for a load, the ALU result register otherwise), or, for the second operand only, the immediate field.

When stage 2 holds a load whose destination is a source that the stage 1 instruction really reads, the block asks for a one-cycle interlock. The PC and the stage 1 instruction register keep their contents, and a NOP is put into stage 2 while the load moves on to stage 3. In the next cycle the loaded value reaches stage 1 through the stage 3 forwarding path. The block is purely combinational. It sits between the stage registers and the operand multiplexers and enable pins they control.

Top module: `ld_use_hazard_unit`

## Requirements
- R1: Operand select codes are 0 = register file, 1 = stage 2 ALU output, 2 = stage 3 write-back value, 3 = immediate. The class codes are 0 NOP, 1 register-register, 2 register-immediate, 3 load, 4 store, 5 branch. A source with no matching writer selects 0.
- R2: A register-register instruction in stage 2 writes its rd field, and a register-immediate one writes its rt field. When that destination equals a stage 1 source, the operand select is 1.
- R3: A register-register, register-immediate or load instruction in stage 3 whose destination equals a stage 1 source, with no stage 2 match, gives select 2. A load writes its rt field.
- R4: When stage 2 and stage 3 both match the same source, the stage 2 result wins (select 1).
- R5: For a stage 1 instruction of class register-immediate, load or store, the second operand select is 3 whatever rt matches.
- R6: For a stage 1 register-register or branch instruction, the second operand select follows the rt comparisons under R1–R4 rules applied to rt.
- R7: Register 0 never matches: a zero destination causes no forwarding and no stall.
- R8: A load in stage 2 whose rt equals stage 1's rs, or stage 1's rt when rt is read, raises pc_hold, s1_hold and s2_bubble together. Otherwise all three are low.
- R9: A stage 2 load matching only the rt field of a stage 1 instruction that uses the immediate causes no stall.
- R10: Store, branch and NOP instructions in stage 2 or 3 never forward or stall. A NOP in stage 1 gets selects 0 (first) and 0 (second) and no stall.
- R11: In the cycle after an interlock, with the load in stage 3 and a NOP in stage 2, the dependent source selects 2 and no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s1_class | input | 3 | Class of the stage 1 instruction |
| s1_rs | input | REG_W | rs field of stage 1 |
| s1_rt | input | REG_W | rt field of stage 1 |
| s2_class | input | 3 | Class of the stage 2 instruction |
| s2_rt | input | REG_W | rt field of stage 2 |
| s2_rd | input | REG_W | rd field of stage 2 |
| s3_class | input | 3 | Class of the stage 3 instruction |
| s3_rt | input | REG_W | rt field of stage 3 |
| s3_rd | input | REG_W | rd field of stage 3 |
| opa_sel | output | 2 | Source select for the first holding register |
| opb_sel | output | 2 | Source select for the second holding register |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| s1_hold | output | 1 | Keep the stage 1 instruction register unchanged |
| s2_bubble | output | 1 | Load a NOP into stage 2 |

## Verification
The bench builds the block with the default REG_W of 5, which gives the 32-entry register space of the pipeline. With 5-bit fields it can place register 0 and high numbers such as 31 on the same comparators. It can also reach every pairing of a stage 2 or stage 3 writer with either stage 1 source, including cases where both stages name the same register. The interlock is walked through two consecutive cycles so that the stall and the later forwarding from stage 3 are seen in order.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    CL_NOP    = 3'd0,
    CL_RTYPE  = 3'd1,
    CL_IMM    = 3'd2,
    CL_LOAD   = 3'd3,
    CL_STORE  = 3'd4,
    CL_BRANCH = 3'd5
  } iclass_e;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_ALU = 2'd1,
    SRC_WB  = 2'd2,
    SRC_IMM = 2'd3
  } opsrc_e;
endpackage

// File: rtl/hz_dest.sv
// Destination decode for one downstream stage.
module hz_dest #(
  parameter int REG_W    = 5,
  parameter bit ALU_ONLY = 1'b1   // 1: stage 2 (ALU output), 0: stage 3 (write-back)
) (
  input  hz_pkg::iclass_e   cls,
  input  logic [REG_W-1:0]  rt,
  input  logic [REG_W-1:0]  rd,
  output logic              wr_en,
  output logic [REG_W-1:0]  dest
);
  import hz_pkg::*;

  logic writes;

  always_comb begin
    dest = (cls == CL_RTYPE) ? rd : rt;
    if (ALU_ONLY)
      writes = (cls == CL_RTYPE) || (cls == CL_IMM);
    else
      writes = (cls == CL_RTYPE) || (cls == CL_IMM) || (cls == CL_LOAD);
    wr_en = writes && (dest != '0);
  end

  // R10
  always_comb begin
    no_store_branch_wr_chk: assert (!(wr_en && (cls == CL_STORE || cls == CL_BRANCH || cls == CL_NOP)));
  end
endmodule

// File: rtl/hz_opsel.sv
// Source select for one ALU holding register.
module hz_opsel #(
  parameter int REG_W = 5,
  parameter bit IS_B  = 1'b0
) (
  input  logic              src_used,
  input  logic [REG_W-1:0]  src,
  input  logic              use_imm,
  input  logic              s2_wr,
  input  logic [REG_W-1:0]  s2_dest,
  input  logic              s3_wr,
  input  logic [REG_W-1:0]  s3_dest,
  output hz_pkg::opsrc_e    sel
);
  import hz_pkg::*;

  logic imm_eff;
  logic hit2, hit3;

  always_comb begin
    imm_eff = IS_B ? use_imm : 1'b0;
    hit2 = src_used && s2_wr && (src == s2_dest);
    hit3 = src_used && s3_wr && (src == s3_dest);
    if (imm_eff)   sel = SRC_IMM;
    else if (hit2) sel = SRC_ALU;
    else if (hit3) sel = SRC_WB;
    else           sel = SRC_RF;
  end

  // R2 R4
  always_comb begin
    alu_fwd_chk: assert (!(sel == SRC_ALU) || (s2_wr && src == s2_dest));
  end
  // R3
  always_comb begin
    wb_fwd_chk: assert (!(sel == SRC_WB) || (s3_wr && src == s3_dest && !(s2_wr && src == s2_dest)));
  end
  // R7
  always_comb begin
    zero_reg_chk: assert (!(sel == SRC_ALU || sel == SRC_WB) || (src != '0));
  end
  // R5
  generate
    if (!IS_B) begin : g_a_chk
      always_comb begin
        no_imm_on_a_chk: assert (sel != SRC_IMM);
      end
    end
  endgenerate
endmodule

// File: rtl/ld_use_hazard_unit.sv
module ld_use_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic [2:0]       s1_class,
  input  logic [REG_W-1:0] s1_rs,
  input  logic [REG_W-1:0] s1_rt,
  input  logic [2:0]       s2_class,
  input  logic [REG_W-1:0] s2_rt,
  input  logic [REG_W-1:0] s2_rd,
  input  logic [2:0]       s3_class,
  input  logic [REG_W-1:0] s3_rt,
  input  logic [REG_W-1:0] s3_rd,
  output logic [1:0]       opa_sel,
  output logic [1:0]       opb_sel,
  output logic             pc_hold,
  output logic             s1_hold,
  output logic             s2_bubble
);
  import hz_pkg::*;

  iclass_e c1, c2, c3;
  logic rs_used, rt_used, b_imm;
  logic s2_wr, s3_wr;
  logic [REG_W-1:0] s2_dest, s3_dest;
  opsrc_e sel_a, sel_b;
  logic s2_is_load, stall;

  assign c1 = iclass_e'(s1_class);
  assign c2 = iclass_e'(s2_class);
  assign c3 = iclass_e'(s3_class);

  always_comb begin
    rs_used = (c1 != CL_NOP);
    rt_used = (c1 == CL_RTYPE) || (c1 == CL_BRANCH);
    b_imm   = (c1 == CL_IMM) || (c1 == CL_LOAD) || (c1 == CL_STORE);
  end

  hz_dest #(.REG_W(REG_W), .ALU_ONLY(1'b1)) u_dest2 (
    .cls(c2), .rt(s2_rt), .rd(s2_rd), .wr_en(s2_wr), .dest(s2_dest)
  );
  hz_dest #(.REG_W(REG_W), .ALU_ONLY(1'b0)) u_dest3 (
    .cls(c3), .rt(s3_rt), .rd(s3_rd), .wr_en(s3_wr), .dest(s3_dest)
  );

  hz_opsel #(.REG_W(REG_W), .IS_B(1'b0)) u_sel_a (
    .src_used(rs_used), .src(s1_rs), .use_imm(1'b0),
    .s2_wr(s2_wr), .s2_dest(s2_dest), .s3_wr(s3_wr), .s3_dest(s3_dest),
    .sel(sel_a)
  );
  hz_opsel #(.REG_W(REG_W), .IS_B(1'b1)) u_sel_b (
    .src_used(rt_used), .src(s1_rt), .use_imm(b_imm),
    .s2_wr(s2_wr), .s2_dest(s2_dest), .s3_wr(s3_wr), .s3_dest(s3_dest),
    .sel(sel_b)
  );

  always_comb begin
    s2_is_load = (c2 == CL_LOAD) && (s2_rt != '0);
    stall = s2_is_load &&
            ((rs_used && s1_rs == s2_rt) || (rt_used && s1_rt == s2_rt));
  end

  assign opa_sel   = sel_a;
  assign opb_sel   = sel_b;
  assign pc_hold   = stall;
  assign s1_hold   = stall;
  assign s2_bubble = stall;

  // R8
  always_comb begin
    stall_needs_load_chk: assert (!s2_bubble || (c2 == CL_LOAD && s2_rt != '0));
  end
  // R9
  always_comb begin
    imm_rt_no_stall_chk: assert (!(s2_bubble && b_imm) || (s1_rs == s2_rt));
  end
  // R5
  always_comb begin
    imm_sel_chk: assert (!b_imm || opb_sel == 2'd3);
  end
  // R10
  always_comb begin
    nop_s1_chk: assert (!(c1 == CL_NOP) || (opa_sel == 2'd0 && opb_sel == 2'd0 && !s2_bubble));
  end
endmodule

// File: tb/sim_ld_use_hazard_unit.sv
module sim_ld_use_hazard_unit;
  localparam int REG_W = 5;
  localparam logic [2:0] NOP = 3'd0, RT = 3'd1, IM = 3'd2, LD = 3'd3, ST = 3'd4, BR = 3'd5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] s1_class, s2_class, s3_class;
  logic [REG_W-1:0] s1_rs, s1_rt, s2_rt, s2_rd, s3_rt, s3_rd;
  logic [1:0] opa_sel, opb_sel;
  logic pc_hold, s1_hold, s2_bubble;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ld_use_hazard_unit #(.REG_W(REG_W)) u0 (
    .s1_class(s1_class), .s1_rs(s1_rs), .s1_rt(s1_rt),
    .s2_class(s2_class), .s2_rt(s2_rt), .s2_rd(s2_rd),
    .s3_class(s3_class), .s3_rt(s3_rt), .s3_rd(s3_rd),
    .opa_sel(opa_sel), .opb_sel(opb_sel),
    .pc_hold(pc_hold), .s1_hold(s1_hold), .s2_bubble(s2_bubble)
  );

  task automatic put(input logic [2:0] c1, input int rs1, input int rt1,
                     input logic [2:0] c2, input int rt2, input int rd2,
                     input logic [2:0] c3, input int rt3, input int rd3);
    @(negedge clk);
    s1_class = c1; s1_rs = REG_W'(rs1); s1_rt = REG_W'(rt1);
    s2_class = c2; s2_rt = REG_W'(rt2); s2_rd = REG_W'(rd2);
    s3_class = c3; s3_rt = REG_W'(rt3); s3_rd = REG_W'(rd3);
    #1;
  endtask

  task automatic expect_out(input string req, input int a, input int b, input int st);
    logic [4:0] act, exp;
    act = {opa_sel, opb_sel, pc_hold & s1_hold & s2_bubble};
    exp = {2'(a), 2'(b), 1'(st)};
    n_chk++;
    if (act !== exp || (pc_hold !== s1_hold) || (s1_hold !== s2_bubble)) begin
      n_bad++;
      $display("FAIL %s: a/b/stall actual %0d/%0d/%0d%0d%0d expected %0d/%0d/%0d",
               req, opa_sel, opb_sel, pc_hold, s1_hold, s2_bubble, a, b, st);
    end
  endtask

  task automatic t_idle;   // R1 R10
    put(NOP, 0, 0, NOP, 0, 0, NOP, 0, 0);
    expect_out("R10 nop everywhere", 0, 0, 0);
    put(RT, 4, 6, RT, 9, 10, IM, 11, 0);
    expect_out("R1 no match", 0, 0, 0);
  endtask

  task automatic t_alu_fwd;  // R2 R6
    put(RT, 7, 3, RT, 1, 7, NOP, 0, 0);
    expect_out("R2 rtype rd to rs", 1, 0, 0);
    put(BR, 2, 12, IM, 12, 9, NOP, 0, 0);
    expect_out("R2 R6 imm rt to branch rt", 0, 1, 0);
    put(RT, 31, 31, RT, 0, 31, NOP, 0, 0);
    expect_out("R2 both sources", 1, 1, 0);
  endtask

  task automatic t_wb_fwd;  // R3 R4
    put(RT, 8, 2, NOP, 0, 0, LD, 8, 0);
    expect_out("R3 load wb to rs", 2, 0, 0);
    put(RT, 1, 5, ST, 5, 5, RT, 0, 5);
    expect_out("R3 R10 store in s2 ignored", 0, 2, 0);
    put(RT, 6, 6, RT, 0, 6, IM, 6, 0);
    expect_out("R4 s2 wins", 1, 1, 0);
  endtask

  task automatic t_imm;  // R5
    put(IM, 3, 14, RT, 0, 14, RT, 0, 14);
    expect_out("R5 imm ignores rt", 0, 3, 0);
    put(ST, 14, 20, IM, 14, 0, NOP, 0, 0);
    expect_out("R5 store imm b, rs fwd", 1, 3, 0);
  endtask

  task automatic t_zero;  // R7
    put(RT, 0, 0, RT, 0, 0, LD, 0, 0);
    expect_out("R7 reg0 no fwd", 0, 0, 0);
    put(RT, 0, 0, LD, 0, 0, NOP, 0, 0);
    expect_out("R7 reg0 no stall", 0, 0, 0);
  endtask

  task automatic t_interlock;  // R8 R9 R11
    put(RT, 9, 4, LD, 9, 0, NOP, 0, 0);
    expect_out("R8 load-use rs stall", 0, 0, 1);
    put(RT, 9, 4, NOP, 0, 0, LD, 9, 0);
    expect_out("R11 after stall fwd wb", 2, 0, 0);
    put(BR, 1, 17, LD, 17, 0, NOP, 0, 0);
    expect_out("R8 load-use rt stall", 0, 0, 1);
    put(IM, 2, 17, LD, 17, 0, NOP, 0, 0);
    expect_out("R9 imm rt no stall", 0, 3, 0);
    put(NOP, 17, 17, LD, 17, 0, NOP, 0, 0);
    expect_out("R10 nop s1 no stall", 0, 0, 0);
    put(RT, 5, 6, BR, 5, 5, BR, 6, 6);
    expect_out("R10 branch no fwd", 0, 0, 0);
  endtask

  initial begin
    t_idle();
    t_alu_fwd();
    t_wb_fwd();
    t_imm();
    t_zero();
    t_interlock();
    done = 1'b1;
  end

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule